// File: doc/BRIEF.md
# Enable-Bounded Static RAM Write Sequencer

This block turns single-word write requests from synchronous logic into write cycles on an external asynchronous static RAM in which the chip select, not the write strobe, bounds the write. The host presents an address and a data word under a valid/ready handshake. The sequencer then walks a fixed series of steps. It drives the address and the data bus and lowers the write strobe. It lowers the chip select and holds it low for a counted pulse. It raises the chip select, which ends the write. It then raises the write strobe and releases the bus. Last, it pads the cycle out to the minimum write-cycle period.

The memory's minimum timings are parameters in nanoseconds, next to the clock period. Each is rounded up to whole clock cycles at elaboration. The write strobe is always low before the chip select falls and still low after the chip select rises, so the memory never turns on its output drivers during the cycle. A one-cycle completion pulse marks the end of the padding, and the sequencer accepts a new request in the cycle that follows.

Top module: `sramWriteSeq`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select and write strobe are high, the bus enable is low, ready is high and done is low.
- R2: Ready is high only while the sequencer is idle. A request is taken on a clock edge where valid and ready are both high. Ready stays low, and no further request is taken, until the current cycle has finished.
- R3: The write strobe goes low at least one clock before the chip select goes low.
- R4: The chip select goes high at least one clock before the write strobe goes high. The write strobe is low for the whole time the chip select is low.
- R5: The chip select stays low for at least the pulse-width minimum in nanoseconds, and never for less than one clock.
- R6: The bus enable rises together with the write strobe and before the chip select falls. It falls only after the chip select has risen. From bus enable rise to chip select rise is at least the data-setup minimum.
- R7: The address changes together with the falling write strobe and then holds until the write strobe rises. From that change to chip select rise is at least the address-to-end-of-write minimum.
- R8: Two successive address changes are at least the write-cycle minimum apart, even when requests arrive back to back.
- R9: Done is a single-cycle pulse, once per write, with both strobes high and the bus released. Ready is high in the cycle after it.
- R10: The address and data on the memory pins equal those presented at the accepted handshake. Changes to the request inputs after the handshake have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqAddr | input | ADDR_W | Requested write address |
| reqData | input | DATA_W | Requested write data |
| wrDone | output | 1 | One-cycle pulse when the write cycle, padding included, is complete |
| memAddr | output | ADDR_W | Address to the memory |
| memDq | output | DATA_W | Data driven toward the memory bus |
| memDqOe | output | 1 | Tri-state enable for memDq, high to drive |
| memCeN | output | 1 | Active-low chip select |
| memWeN | output | 1 | Active-low write strobe |

## Verification
The properties assume the host holds reset long enough for every output register to reach its idle value. They also assume that the chip select is never expected to fall unless a request was taken, so each low pulse of the chip select belongs to exactly one accepted write. The stimulus keeps within this: it changes request inputs only on falling clock edges, holds valid until it sees ready, and then scrambles address and data so that late capture would show up. Three timing sets are applied. The first is a fast grade. The second is a slow grade with a stretched cycle time that forces several cycles of padding. The third has nanosecond values below one clock, so every step shrinks to its one-cycle floor.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR_W  = 3'd1,
    ST_EN_LOW  = 3'd2,
    ST_EN_HIGH = 3'd3,
    ST_W_HIGH  = 3'd4,
    ST_RECOVER = 3'd5
  } seqState_t;

  // Strobes from control to datapath, applied on the edge where the state changes.
  typedef struct packed {
    logic load;      // capture request, drive bus
    logic wAssert;   // write strobe low
    logic eAssert;   // chip select low
    logic eRelease;  // chip select high
    logic wRelease;  // write strobe high, bus off
  } seqStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Chip-select low cycles. The address/data phase supplies one cycle before
  // the chip select falls, so the setup minimums need one cycle less.
  function automatic int lowCycles(input int clkNs, input int pulseNs,
                                   input int dsuNs, input int avehNs);
    int n;
    n = ceilDiv(pulseNs, clkNs);
    if (ceilDiv(dsuNs, clkNs) - 1 > n) n = ceilDiv(dsuNs, clkNs) - 1;
    if (ceilDiv(avehNs, clkNs) - 1 > n) n = ceilDiv(avehNs, clkNs) - 1;
    if (n < 1) n = 1;
    return n;
  endfunction

  // Padding cycles. A whole period spans the address phase, the low phase,
  // the two release steps, the padding and at least one idle cycle.
  function automatic int recCycles(input int clkNs, input int cycleNs, input int lowCyc);
    int n;
    n = ceilDiv(cycleNs, clkNs) - lowCyc - 4;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int LOW_CYC = 2,
  parameter int REC_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       wrDone,
  output seqStrobe_t strobe
);

  localparam int CNT_MAX = (LOW_CYC > REC_CYC) ? LOW_CYC : REC_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext      = ST_ADDR_W;
          strobe.load    = 1'b1;
          strobe.wAssert = 1'b1;
        end
      end
      ST_ADDR_W: begin
        stateNext      = ST_EN_LOW;
        strobe.eAssert = 1'b1;
        cntNext        = CNT_W'(LOW_CYC - 1);
      end
      ST_EN_LOW: begin
        if (cnt == '0) begin
          stateNext       = ST_EN_HIGH;
          strobe.eRelease = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_EN_HIGH: begin
        stateNext       = ST_W_HIGH;
        strobe.wRelease = 1'b1;
      end
      ST_W_HIGH: begin
        stateNext = ST_RECOVER;
        cntNext   = CNT_W'(REC_CYC - 1);
      end
      ST_RECOVER: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign wrDone   = (state == ST_RECOVER) && (cnt == '0);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDq,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memDq   <= '0;
    end else if (strobe.load) begin
      memAddr <= reqAddr;
      memDq   <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
    end else if (strobe.wAssert) begin
      memWeN  <= 1'b0;
      memDqOe <= 1'b1;
    end else if (strobe.wRelease) begin
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                memCeN <= 1'b1;
    else if (strobe.eAssert)  memCeN <= 1'b0;
    else if (strobe.eRelease) memCeN <= 1'b1;
  end

endmodule

// File: rtl/sramWriteSeq.sv
module sramWriteSeq
  import sram_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int T_PULSE_NS    = 15,
  parameter int T_DSETUP_NS   = 10,
  parameter int T_AVEH_NS     = 15,
  parameter int T_CYCLE_NS    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              wrDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDq,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memWeN
);

  localparam int LOW_CYC = lowCycles(CLK_PERIOD_NS, T_PULSE_NS, T_DSETUP_NS, T_AVEH_NS);
  localparam int REC_CYC = recCycles(CLK_PERIOD_NS, T_CYCLE_NS, LOW_CYC);

  seqStrobe_t strobe;

  sram_seq_ctrl #(.LOW_CYC(LOW_CYC), .REC_CYC(REC_CYC)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .wrDone   (wrDone),
    .strobe   (strobe)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .memAddr (memAddr),
    .memDq   (memDq),
    .memDqOe (memDqOe),
    .memCeN  (memCeN),
    .memWeN  (memWeN)
  );

endmodule

// File: rtl/sramWriteSeq_chk.sv
module sramWriteSeq_chk #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int LOW_MIN = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              wrDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDq,
  input logic              memDqOe,
  input logic              memCeN,
  input logic              memWeN
);

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)        lowRun <= '0;
    else if (!memCeN) lowRun <= lowRun + 1'b1;
    else              lowRun <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && !memDqOe)); // R2
  AST_W_LEADS_E: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> !$past(memWeN)); // R3
  AST_W_COVERS_E: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !memWeN); // R4
  AST_E_LEADS_W: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> $past(memCeN)); // R4
  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (lowRun >= 16'(LOW_MIN))); // R5
  AST_BUS_COVERS_E: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> memDqOe); // R6
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDq)); // R6
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone); // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> (memCeN && memWeN && !memDqOe)); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> reqReady); // R9

endmodule

bind sramWriteSeq sramWriteSeq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LOW_MIN(LOW_CYC)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .wrDone   (wrDone),
  .memAddr  (memAddr),
  .memDq    (memDq),
  .memDqOe  (memDqOe),
  .memCeN   (memCeN),
  .memWeN   (memWeN)
);

// File: tb/sramWriteSeq_test.sv
`timescale 1ns/1ps

module sramWriteSeq_harness #(
  parameter int    CLK_NS  = 8,
  parameter int    T_PULSE = 15,
  parameter int    T_DSU   = 10,
  parameter int    T_AVEH  = 15,
  parameter int    T_CYC   = 20,
  parameter string NAME    = "set"
) (
  input  logic clk,
  input  logic rstN,
  output logic finished
);

  localparam int AW = 12;
  localparam int DW = 8;

  logic          reqValid;
  logic          reqReady;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqData;
  logic          wrDone;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDq;
  logic          memDqOe;
  logic          memCeN;
  logic          memWeN;

  sramWriteSeq #(
    .CLK_PERIOD_NS(CLK_NS), .ADDR_W(AW), .DATA_W(DW),
    .T_PULSE_NS(T_PULSE), .T_DSETUP_NS(T_DSU), .T_AVEH_NS(T_AVEH), .T_CYCLE_NS(T_CYC)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .wrDone(wrDone), .memAddr(memAddr),
    .memDq(memDq), .memDqOe(memDqOe), .memCeN(memCeN), .memWeN(memWeN)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int writes  = 0;
  int dones   = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL [%s] %s: actual %0d expected %0d", NAME, req, act, exp);
    end
  endtask

  // Monitor: samples at falling edges, records edge cycles, scores writes.
  longint   cyc = 0, tWfall = -1, tEfall = -1, tErise = -1, tOeRise = -1, prevWfall = -1;
  logic     pE = 1'b1, pW = 1'b1, pOe = 1'b0;
  logic [AW-1:0] addrAtW = '0;
  bit       doneSeen = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      pE = 1'b1; pW = 1'b1; pOe = 1'b0; doneSeen = 0;
    end else begin
      cyc++;
      if (doneSeen) begin
        chk(reqReady, "R9 ready in cycle after done", reqReady, 1);
        doneSeen = 0;
      end
      if (wrDone) begin
        dones++;
        doneSeen = 1;
        chk(memCeN && memWeN && !memDqOe, "R9 strobes released at done",
            {memCeN, memWeN, memDqOe}, 3'b110);
      end
      if (pW && !memWeN) begin
        if (prevWfall >= 0)
          chk((cyc - prevWfall) * CLK_NS >= T_CYC, "R8 address change spacing ns",
              (cyc - prevWfall) * CLK_NS, T_CYC);
        prevWfall = cyc;
        tWfall    = cyc;
        addrAtW   = memAddr;
        chk(memCeN, "R3 chip select still high as W falls", memCeN, 1);
      end
      if (!pOe && memDqOe) tOeRise = cyc;
      if (pE && !memCeN) begin
        tEfall = cyc;
        chk(tWfall >= 0 && cyc > tWfall, "R3 W low cycles before E low", cyc - tWfall, 1);
        chk(!reqReady, "R2 ready low while busy", reqReady, 0);
        chk(memDqOe, "R6 bus driven when E falls", memDqOe, 1);
      end
      if (!pE && memCeN) begin
        chk((cyc - tEfall) * CLK_NS >= T_PULSE && cyc - tEfall >= 1,
            "R5 chip select low width ns", (cyc - tEfall) * CLK_NS, T_PULSE);
        chk((cyc - tOeRise) * CLK_NS >= T_DSU, "R6 data valid to E rise ns",
            (cyc - tOeRise) * CLK_NS, T_DSU);
        chk((cyc - tWfall) * CLK_NS >= T_AVEH, "R7 address valid to E rise ns",
            (cyc - tWfall) * CLK_NS, T_AVEH);
        chk(!memWeN, "R4 W still low when E rises", memWeN, 0);
        if (expQ.size() == 0) begin
          chk(0, "R10 write with no accepted request", memAddr, -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(memAddr == e.a, "R10 written address", memAddr, e.a);
          chk(memDq == e.d, "R10 written data", memDq, e.d);
        end
        tErise = cyc;
      end
      if (!pW && memWeN) begin
        chk(memCeN && tErise >= 0 && cyc > tErise, "R4 E high cycles before W high",
            cyc - tErise, 1);
        chk(memAddr == addrAtW, "R7 address held until W rises", memAddr, addrAtW);
      end
      if (pOe && !memDqOe)
        chk(memCeN && cyc > tErise, "R6 bus released after E rise", cyc - tErise, 1);
      pE = memCeN; pW = memWeN; pOe = memDqOe;
    end
  end

  // Driver: present a request, wait for the handshake, then scramble inputs.
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit acc;
    reqValid = 1'b1;
    reqAddr  = a;
    reqData  = d;
    expQ.push_back('{a: a, d: d});
    forever begin
      acc = reqReady;
      @(negedge clk);
      if (acc) break;
    end
    reqValid = 1'b0;
    reqAddr  = ~a;   // R10: late changes must not reach the pins
    reqData  = ~d;
    writes++;
  endtask

  initial begin
    finished = 1'b0;
    reqValid = 1'b0;
    reqAddr  = '0;
    reqData  = '0;
    @(negedge clk);
    chk(memCeN && memWeN && !memDqOe, "R1 strobes idle during reset",
        {memCeN, memWeN, memDqOe}, 3'b110);
    wait (rstN);
    @(negedge clk);
    chk(memCeN, "R1 chip select high after reset", memCeN, 1);
    chk(memWeN, "R1 write strobe high after reset", memWeN, 1);
    chk(!memDqOe, "R1 bus released after reset", memDqOe, 0);
    chk(reqReady, "R1 ready after reset", reqReady, 1);
    chk(!wrDone, "R1 done low after reset", wrDone, 0);
    doWrite('1, 8'hFF);
    doWrite('0, 8'h00);
    doWrite(12'hA5A, 8'h5A);
    repeat (5) @(negedge clk);
    doWrite(12'h5A5, 8'hA5);
    for (int i = 0; i < 6; i++) begin
      doWrite(AW'(i * 37 + 1), DW'(i * 19 + 3));
      if (i % 3 == 2) repeat (3) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk(dones == writes, "R9 one done per write", dones, writes);
    chk(expQ.size() == 0, "R10 every accepted write seen on pins", expQ.size(), 0);
    finished = 1'b1;
  end

endmodule

module sramWriteSeq_test;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  logic f0, f1, f2;

  always #4 clk = ~clk;

  // Fast grade.
  sramWriteSeq_harness #(.CLK_NS(8), .T_PULSE(15), .T_DSU(10), .T_AVEH(15), .T_CYC(20),
                         .NAME("fast")) h0 (.clk(clk), .rstN(rstN), .finished(f0));
  // Slow grade with a stretched cycle time to force padding.
  sramWriteSeq_harness #(.CLK_NS(8), .T_PULSE(25), .T_DSU(20), .T_AVEH(25), .T_CYC(120),
                         .NAME("slow")) h1 (.clk(clk), .rstN(rstN), .finished(f1));
  // Sub-clock timings: every step falls to its one-cycle floor.
  sramWriteSeq_harness #(.CLK_NS(8), .T_PULSE(5), .T_DSU(2), .T_AVEH(5), .T_CYC(6),
                         .NAME("floor")) h2 (.clk(clk), .rstN(rstN), .finished(f2));

  initial begin
    int total, bad;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 20000 && !(f0 && f1 && f2); i++) @(posedge clk);
    total = h0.nChecks + h1.nChecks + h2.nChecks;
    bad   = h0.nFails + h1.nFails + h2.nFails;
    if (!(f0 && f1 && f2)) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

endmodule